// File: doc/BRIEF.md
# Halt Mode Power Sequencer

This block controls entry into and exit from the deepest sleep state of a small microcontroller. When the CPU issues a halt request and the oscillator-interrupt configuration bit is clear, the sequencer either enters the halted state or, if the watchdog is running and the watchdog-halt option asks for it, raises a watchdog reset pulse instead. On entry the two-bit interrupt mask field seen by the CPU is forced to binary 10, so interrupts are enabled during sleep.

While halted, the oscillator, the CPU clock and the peripheral clocks are all off. A reset event or an interrupt from the wake-capable subset ends the halt. The oscillator then restarts at once, and a settling count of 256 or 4096 cycles runs before the clocks are released. A one-cycle pulse then tells the CPU whether to service the interrupt or fetch the reset vector. A reset that arrives during the settling count restarts the count and turns the pending resume into a reset-vector fetch.

Top module: `halt_seq`

## Requirements
- R1: A halt request while `osc_irq_en` is 1 has no effect: the state stays RUN (code 0), all clocks stay on, `irq_mask` keeps following `cpu_mask`, and no pulse is produced.
- R2: A halt request with `osc_irq_en` 0, `wdg_on` 1 and `wdg_halt_opt` 1 gives a one-cycle `wdg_reset_pulse` in the cycle after the request, and the state stays RUN.
- R3: A halt request with `osc_irq_en` 0 and no watchdog trip moves to HALTED (code 1) in the next cycle. `wdg_disable` then equals the `wdg_on` value at the request and holds until the resume pulse cycle, when it drops to 0.
- R4: From the cycle after halt entry until the resume pulse cycle, `irq_mask` reads binary 10. At all other times it equals `cpu_mask`.
- R5: If a wake-capable interrupt (a bit set in both `irq_pend` and `irq_wake_mask`) or `ext_reset` is present in the entry cycle, the sequencer goes straight to STABILIZING (code 2) without a HALTED cycle.
- R6: In RUN, `osc_en`, `cpu_clk_en` and `periph_clk_en` are 1. In HALTED all three are 0. In STABILIZING only `osc_en` is 1.
- R7: While HALTED, only `ext_reset` or a wake-capable interrupt causes a move to STABILIZING. Pending interrupts whose `irq_wake_mask` bit is 0 are ignored.
- R8: STABILIZING lasts exactly 256 cycles when `long_delay` was 0 in the wake cycle, and exactly 4096 cycles when it was 1. The state then returns to RUN.
- R9: In the first RUN cycle after STABILIZING, exactly one of `resume_irq` and `resume_reset` is 1 for one cycle, matching the wake cause. `ext_reset` takes priority over a simultaneous interrupt.
- R10: `ext_reset` during STABILIZING restarts the full settling count from that cycle and makes the resume a `resume_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (stands for the restarted oscillator clock) |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| halt_req | input | 1 | One-cycle halt request from the CPU |
| osc_irq_en | input | 1 | Configuration bit; when 1 it blocks halt entry |
| wdg_on | input | 1 | Watchdog currently enabled |
| wdg_halt_opt | input | 1 | Option: a halt request with the watchdog on causes a watchdog reset |
| long_delay | input | 1 | Settling count select: 0 for 256 cycles, 1 for 4096 cycles |
| irq_pend | input | IRQ_W | Pending interrupt lines |
| irq_wake_mask | input | IRQ_W | Marks which lines may end a halt |
| ext_reset | input | 1 | Reset wake event |
| cpu_mask | input | 2 | Interrupt mask field driven by the CPU |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate |
| periph_clk_en | output | 1 | Peripheral clock gate |
| irq_mask | output | 2 | Effective interrupt mask field |
| wdg_disable | output | 1 | Holds the watchdog off during halt |
| wdg_reset_pulse | output | 1 | Watchdog reset request instead of halt |
| resume_irq | output | 1 | Pulse: resume by servicing the interrupt |
| resume_reset | output | 1 | Pulse: resume by fetching the reset vector |
| seq_state | output | 2 | 0 RUN, 1 HALTED, 2 STABILIZING |

## Verification
The assertions check every cycle that RUN is left only after a qualified halt request, that the mask reads 10 whenever the sequencer is out of RUN, that HALTED persists without a wake event, that a reset during settling clears the count, and that the resume pulses are exclusive and appear only when leaving STABILIZING. The settling length of exactly 256 or 4096 cycles, reset priority over a simultaneous interrupt, the skip past HALTED when a wake source is pending at entry, and the cause change after a mid-count reset are shown by the bench scenarios against its cycle model.

// File: rtl/halt_seq_pkg.sv
package halt_seq_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_SETTLE = 2'd2
  } seq_state_e;

  typedef enum logic {
    CAUSE_IRQ = 1'b0,
    CAUSE_RST = 1'b1
  } wake_cause_e;

  localparam logic [1:0] HALT_MASK_CODE = 2'b10;

  // settling length picked by the select bit
  function automatic int unsigned settle_cycles(input logic sel,
                                                input int unsigned short_n,
                                                input int unsigned long_n);
    return sel ? long_n : short_n;
  endfunction

  // final count value of a settling window of n cycles
  function automatic int unsigned settle_last(input int unsigned n);
    return n - 1;
  endfunction

endpackage

// File: rtl/halt_entry_gate.sv
module halt_entry_gate (
  input  logic halt_req,
  input  logic osc_irq_en,
  input  logic wdg_on,
  input  logic wdg_halt_opt,
  output logic enter_ok,
  output logic wdg_trip
);
  logic qualified;

  always_comb begin
    qualified = halt_req & ~osc_irq_en;
    wdg_trip  = qualified & wdg_on & wdg_halt_opt;
    enter_ok  = qualified & ~(wdg_on & wdg_halt_opt);
  end
endmodule

// File: rtl/halt_wake_sel.sv
module halt_wake_sel
  import halt_seq_pkg::*;
#(
  parameter int IRQ_W = 8
) (
  input  logic [IRQ_W-1:0] irq_pend,
  input  logic [IRQ_W-1:0] irq_wake_mask,
  input  logic             ext_reset,
  output logic             wake_any,
  output logic             wake_irq,
  output wake_cause_e      wake_cause
);
  logic [IRQ_W-1:0] hit;

  for (genvar i = 0; i < IRQ_W; i++) begin : g_line
    assign hit[i] = irq_pend[i] & irq_wake_mask[i];
  end

  always_comb begin
    wake_irq   = |hit;
    wake_any   = wake_irq | ext_reset;
    wake_cause = ext_reset ? CAUSE_RST : CAUSE_IRQ;
  end
endmodule

// File: rtl/halt_settle_timer.sv
module halt_settle_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] last,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
  end

  assign done = run & ~clr & (cnt == last);
endmodule

// File: rtl/halt_seq.sv
module halt_seq
  import halt_seq_pkg::*;
#(
  parameter int IRQ_W    = 8,
  parameter int SHORT_N  = 256,
  parameter int LONG_N   = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_req,
  input  logic             osc_irq_en,
  input  logic             wdg_on,
  input  logic             wdg_halt_opt,
  input  logic             long_delay,
  input  logic [IRQ_W-1:0] irq_pend,
  input  logic [IRQ_W-1:0] irq_wake_mask,
  input  logic             ext_reset,
  input  logic [1:0]       cpu_mask,
  output logic             osc_en,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic [1:0]       irq_mask,
  output logic             wdg_disable,
  output logic             wdg_reset_pulse,
  output logic             resume_irq,
  output logic             resume_reset,
  output logic [1:0]       seq_state
);
  localparam int CNT_W = $clog2(LONG_N + 1);

  seq_state_e  state_q, state_d;
  wake_cause_e cause_q;
  logic        sel_q;
  logic        force_q;
  logic        wdis_q;
  logic        wtrip_q;
  logic        res_irq_q, res_rst_q;

  // named internal events
  logic        enter_ok, wdg_trip;
  logic        wake_any, wake_irq;
  wake_cause_e wake_cause;
  logic        wake_start;
  logic        settle_restart;
  logic        settle_done;
  logic        timer_clr;
  logic [CNT_W-1:0] settle_cnt;
  logic [CNT_W-1:0] settle_lim;

  halt_entry_gate u_gate (
    .halt_req     (halt_req),
    .osc_irq_en   (osc_irq_en),
    .wdg_on       (wdg_on),
    .wdg_halt_opt (wdg_halt_opt),
    .enter_ok     (enter_ok),
    .wdg_trip     (wdg_trip)
  );

  halt_wake_sel #(.IRQ_W(IRQ_W)) u_wake (
    .irq_pend      (irq_pend),
    .irq_wake_mask (irq_wake_mask),
    .ext_reset     (ext_reset),
    .wake_any      (wake_any),
    .wake_irq      (wake_irq),
    .wake_cause    (wake_cause)
  );

  assign settle_lim = CNT_W'(settle_last(settle_cycles(sel_q, SHORT_N, LONG_N)));

  assign wake_start = ((state_q == ST_RUN) && enter_ok && wake_any) ||
                      ((state_q == ST_HALT) && wake_any);
  assign settle_restart = (state_q == ST_SETTLE) && ext_reset;
  assign timer_clr = wake_start | settle_restart;

  halt_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (timer_clr),
    .run   (state_q == ST_SETTLE),
    .last  (settle_lim),
    .cnt   (settle_cnt),
    .done  (settle_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (enter_ok) state_d = wake_any ? ST_SETTLE : ST_HALT;
      ST_HALT:   if (wake_any) state_d = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      cause_q   <= CAUSE_IRQ;
      sel_q     <= 1'b0;
      force_q   <= 1'b0;
      wdis_q    <= 1'b0;
      wtrip_q   <= 1'b0;
      res_irq_q <= 1'b0;
      res_rst_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      wtrip_q   <= (state_q == ST_RUN) && wdg_trip;
      res_irq_q <= settle_done && (cause_q == CAUSE_IRQ);
      res_rst_q <= settle_done && (cause_q == CAUSE_RST);
      if ((state_q == ST_RUN) && enter_ok) begin
        force_q <= 1'b1;
        wdis_q  <= wdg_on;
      end else if (settle_done) begin
        force_q <= 1'b0;
        wdis_q  <= 1'b0;
      end
      if (wake_start) begin
        cause_q <= wake_cause;
        sel_q   <= long_delay;
      end else if (settle_restart) begin
        cause_q <= CAUSE_RST;
      end
    end
  end

  always_comb begin
    osc_en          = (state_q != ST_HALT);
    cpu_clk_en      = (state_q == ST_RUN);
    periph_clk_en   = (state_q == ST_RUN);
    irq_mask        = force_q ? HALT_MASK_CODE : cpu_mask;
    wdg_disable     = wdis_q;
    wdg_reset_pulse = wtrip_q;
    resume_irq      = res_irq_q;
    resume_reset    = res_rst_q;
    seq_state       = state_q;
  end
endmodule

// File: rtl/halt_seq_chk.sv
module halt_seq_chk #(
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt_req,
  input logic             osc_irq_en,
  input logic             wdg_on,
  input logic             wdg_halt_opt,
  input logic             ext_reset,
  input logic             wake_any,
  input logic [1:0]       seq_state,
  input logic [1:0]       irq_mask,
  input logic             wdg_reset_pulse,
  input logic             resume_irq,
  input logic             resume_reset,
  input logic             cpu_clk_en,
  input logic [CNT_W-1:0] settle_cnt
);
  // R1 R3: RUN is left only after a qualified halt request
  assert_leave_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'd0) ##1 (seq_state != 2'd0) |->
      $past(halt_req && !osc_irq_en && !(wdg_on && wdg_halt_opt)));

  // R2: watchdog pulse follows a tripping request and RUN is kept
  assert_wdg_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdg_reset_pulse) |->
      $past(halt_req && !osc_irq_en && wdg_on && wdg_halt_opt) && seq_state == 2'd0);

  // R4: forced mask whenever out of RUN
  assert_mask_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state != 2'd0) |-> irq_mask == 2'b10);

  // R7: halt persists without a wake event
  assert_halt_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'd1 && !wake_any) |=> seq_state == 2'd1);

  // R10: reset in settling clears the count
  assert_settle_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'd2 && ext_reset) |=> (seq_state == 2'd2 && settle_cnt == '0));

  // R9: resume pulses exclusive, only on leaving settling, with clocks on
  assert_resume_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resume_irq, resume_reset}));
  assert_resume_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_irq || resume_reset) |-> $past(seq_state) == 2'd2 && cpu_clk_en);
endmodule

bind halt_seq halt_seq_chk #(.CNT_W(CNT_W)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .halt_req        (halt_req),
  .osc_irq_en      (osc_irq_en),
  .wdg_on          (wdg_on),
  .wdg_halt_opt    (wdg_halt_opt),
  .ext_reset       (ext_reset),
  .wake_any        (wake_any),
  .seq_state       (seq_state),
  .irq_mask        (irq_mask),
  .wdg_reset_pulse (wdg_reset_pulse),
  .resume_irq      (resume_irq),
  .resume_reset    (resume_reset),
  .cpu_clk_en      (cpu_clk_en),
  .settle_cnt      (settle_cnt)
);

// File: tb/halt_seq_tb_top.sv
module halt_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt_req = 0, osc_irq_en = 0, wdg_on = 0, wdg_halt_opt = 0;
  logic       long_delay = 0, ext_reset = 0;
  logic [7:0] irq_pend = 0, irq_wake_mask = 0;
  logic [1:0] cpu_mask = 2'b00;
  logic       osc_en, cpu_clk_en, periph_clk_en, wdg_disable, wdg_reset_pulse;
  logic       resume_irq, resume_reset;
  logic [1:0] irq_mask, seq_state;

  int total = 0, bad = 0;
  int m_state = 0, m_cnt = 0, m_lim = 256;
  bit m_cause_rst = 0, m_force = 0, m_wdis = 0, m_wtrip = 0, m_ri = 0, m_rr = 0;
  int settle_len = 0;

  always #4 clk = ~clk;

  halt_seq dut_i (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .osc_irq_en(osc_irq_en),
    .wdg_on(wdg_on), .wdg_halt_opt(wdg_halt_opt), .long_delay(long_delay),
    .irq_pend(irq_pend), .irq_wake_mask(irq_wake_mask), .ext_reset(ext_reset),
    .cpu_mask(cpu_mask), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .irq_mask(irq_mask), .wdg_disable(wdg_disable),
    .wdg_reset_pulse(wdg_reset_pulse), .resume_irq(resume_irq),
    .resume_reset(resume_reset), .seq_state(seq_state)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    bit wake, qual, trip;
    wake = ext_reset || ((irq_pend & irq_wake_mask) != 0);
    qual = halt_req && !osc_irq_en;
    trip = qual && wdg_on && wdg_halt_opt;
    if (!rst_n) begin
      m_state = 0; m_force = 0; m_wdis = 0; m_wtrip = 0; m_ri = 0; m_rr = 0; m_cnt = 0;
    end else begin
      m_wtrip = (m_state == 0) && trip;
      m_ri = 0; m_rr = 0;
      case (m_state)
        0: if (qual && !trip) begin
             m_force = 1; m_wdis = wdg_on;
             if (wake) begin
               m_state = 2; m_cnt = 0; m_cause_rst = ext_reset;
               m_lim = long_delay ? 4096 : 256;
             end else m_state = 1;
           end
        1: if (wake) begin
             m_state = 2; m_cnt = 0; m_cause_rst = ext_reset;
             m_lim = long_delay ? 4096 : 256;
           end
        default: begin
          if (ext_reset) begin m_cnt = 0; m_cause_rst = 1; end
          else if (m_cnt == m_lim - 1) begin
            m_state = 0; m_force = 0; m_wdis = 0;
            m_ri = !m_cause_rst; m_rr = m_cause_rst;
          end else m_cnt++;
        end
      endcase
    end
  end

  // compare every cycle, clear of both edges
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      check(seq_state == 2'(m_state), "R8 state", seq_state, m_state);
      check(osc_en == (m_state != 1), "R6 osc_en", osc_en, m_state != 1);
      check(cpu_clk_en == (m_state == 0) && periph_clk_en == (m_state == 0),
            "R6 clocks", {cpu_clk_en, periph_clk_en}, (m_state == 0) ? 3 : 0);
      check(irq_mask == (m_force ? 2'b10 : cpu_mask), "R4 mask", irq_mask,
            m_force ? 2 : cpu_mask);
      check(wdg_disable == m_wdis, "R3 wdg_disable", wdg_disable, m_wdis);
      check(wdg_reset_pulse == m_wtrip, "R2 wdg pulse", wdg_reset_pulse, m_wtrip);
      check(resume_irq == m_ri && resume_reset == m_rr, "R9 resume",
            {resume_irq, resume_reset}, {m_ri, m_rr});
      if (seq_state == 2) settle_len++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request();
    halt_req = 1; @(negedge clk); halt_req = 0;
  endtask

  task automatic wait_run();
    while (seq_state != 0) @(negedge clk);
  endtask

  initial begin : watchdog
    #1_400_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    check(seq_state == 0 && osc_en && cpu_clk_en && !resume_irq && !resume_reset,
          "R6 reset state", seq_state, 0);
    rst_n = 1; cpu_mask = 2'b01; tick(2);

    // R1: blocked by osc_irq_en
    osc_irq_en = 1; request(); tick(3);
    check(seq_state == 0 && irq_mask == 2'b01, "R1 blocked", seq_state, 0);
    osc_irq_en = 0;

    // R2: watchdog trip
    wdg_on = 1; wdg_halt_opt = 1; halt_req = 1; @(negedge clk); halt_req = 0;
    check(wdg_reset_pulse == 1 && seq_state == 0, "R2 trip", wdg_reset_pulse, 1);
    tick(1);
    check(wdg_reset_pulse == 0, "R2 one cycle", wdg_reset_pulse, 0);

    // R3 R7 R8: enter with watchdog disabled, masked irq ignored, irq wake short
    wdg_halt_opt = 0; irq_wake_mask = 8'h0F; request();
    check(seq_state == 1 && wdg_disable && irq_mask == 2'b10, "R3 entry", seq_state, 1);
    irq_pend = 8'hF0; tick(10);
    check(seq_state == 1 && !osc_en, "R7 masked ignored", seq_state, 1);
    settle_len = 0; irq_pend = 8'h12; tick(1); irq_pend = 0;
    wait_run();
    check(settle_len == 256, "R8 short length", settle_len, 256);
    check(resume_irq == 1, "R9 irq resume", resume_irq, 1);
    tick(1);
    check(wdg_disable == 0, "R3 released", wdg_disable, 0);

    // R9: simultaneous reset and irq, long delay
    wdg_on = 0; request(); tick(2);
    long_delay = 1; irq_pend = 8'h01; ext_reset = 1; settle_len = 0;
    tick(1); ext_reset = 0; irq_pend = 0; long_delay = 0;
    wait_run();
    check(settle_len == 4096, "R8 long length", settle_len, 4096);
    check(resume_reset == 1 && resume_irq == 0, "R9 reset priority", resume_reset, 1);

    // R10: reset mid-count restarts
    tick(2); request(); tick(1);
    irq_pend = 8'h04; settle_len = 0; tick(1); irq_pend = 0;
    tick(100); ext_reset = 1; tick(1); ext_reset = 0;
    wait_run();
    check(settle_len == 101 + 256, "R10 restart length", settle_len, 357);
    check(resume_reset == 1, "R10 cause reset", resume_reset, 1);

    // R5: wake irq pending at entry skips HALTED
    tick(2); irq_pend = 8'h08; halt_req = 1; @(negedge clk); halt_req = 0; irq_pend = 0;
    check(seq_state == 2, "R5 direct settle", seq_state, 2);
    wait_run();
    check(resume_irq == 1, "R5 irq resume", resume_irq, 1);
    tick(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule